// File: doc/BRIEF.md
# Write-Triggered Interrupt Request Decoder

This block takes memory-mapped write cycles that replace physical interrupt wires and turns each one into a pending edge-style request. A peripheral that has been given the address of the pin-assertion register writes a 32-bit word there. The low five bits of that word carry the binary number of the interrupt line to raise. The block claims the cycle only when the internal interrupt controller is enabled and the message capability is reported. It then screens the line number against the valid range, the reserved lines and each line's trigger mode and enable, and sets one bit of a 24-bit request register.

A round-robin selector offers one pending line at a time on a valid/ready delivery port. When the delivery side accepts a line, its request bit clears on the same clock edge. No software acknowledge is needed. A new write that targets the same line in that cycle takes priority over the clear. Reads of the register are claimed and return zero.

Top module: `msgirq_decoder`

## Requirements
- R1: A synchronous active-high `rst` clears `pending`, `dlv_valid`, `mode_err`, `cap_status` and `bus_claim`.
- R2: A write (`bus_write`=1) to `BASE_ADDR`+20h whose data bits [4:0] hold a legal line number n sets `pending[n]` on that clock edge. `bus_claim` is 1 in the following cycle. Data bits [31:5] are ignored, and writes to any other address have no effect.
- R3: A write is claimed and decoded only while `ctrl_enable`=1 and `cap_request`=1 and `ext_enable`=1. Otherwise it has no effect.
- R4: `cap_status` equals `cap_request` AND `ext_enable`, registered one cycle, so it reads 0 whenever `ext_enable` is 0.
- R5: Line numbers 24 to 31 cause no action.
- R6: Line numbers 0, 2, 8 and 13 are reserved and cause no action.
- R7: A write to a legal line whose `line_level` bit is 1 (level-triggered) leaves `pending` unchanged and sets `mode_err`. `mode_err` stays set until reset.
- R8: A write to a legal edge line whose `line_en` bit is 0 leaves `pending` unchanged and does not set `mode_err`.
- R9: When `dlv_valid` is 1, `dlv_line` names a set `pending` bit. A cycle with `dlv_valid` and `dlv_ready` both 1 clears that bit on the edge. `dlv_valid` rises on the same edge that sets a bit in an empty register.
- R10: If a write sets line n in the same cycle that the delivery side accepts line n, `pending[n]` stays 1.
- R11: After line n is accepted, the next line offered is the first pending index above n, wrapping past 23 to 0. After reset the search starts at line 0.
- R12: While `dlv_valid`=1 and `dlv_ready`=0, `dlv_valid` stays 1 and `dlv_line` does not change, even when lower-numbered lines become pending.
- R13: A read (`bus_write`=0) of the target address is claimed and returns `bus_rdata`=0, and it sets no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Slave cycle strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 32 | Cycle address |
| bus_wdata | input | 32 | Write data, bits [4:0] = line number |
| bus_rdata | output | 32 | Read data, always zero |
| bus_claim | output | 1 | Cycle of previous clock was claimed |
| ctrl_enable | input | 1 | Internal interrupt controller enabled |
| ext_enable | input | 1 | Extended controller enable |
| cap_request | input | 1 | Request to report message capability |
| cap_status | output | 1 | Message capability status |
| line_level | input | 24 | Per-line trigger mode, 1 = level |
| line_en | input | 24 | Per-line enable |
| pending | output | 24 | Request register |
| mode_err | output | 1 | Sticky level-line write error |
| dlv_valid | output | 1 | A pending line is offered |
| dlv_line | output | 5 | Offered line number |
| dlv_ready | input | 1 | Delivery side accepts the offered line |

## Verification
The decode is exercised with legal numbers that carry junk in the upper data bits, with numbers just inside and just outside the range (23, 24, 31), and with each reserved number. These patterns separate a range check from a blacklist check and a 5-bit decode from a wider one. Separate runs clear each gating input in turn, which shows that every enable term is needed. Level-mode and disabled lines are written next to normal lines to show the drop-with-error and silent-drop paths. The delivery port is driven with three scattered lines in a chosen order. Accepted one by one, they expose round-robin order as opposed to lowest-first, the hold rule while ready is low, and a set and a clear of the same line landing in the same cycle.

// File: rtl/msgirq_pkg.sv
package msgirq_pkg;
  localparam int unsigned DEF_ADDR_W    = 32;
  localparam int unsigned DEF_DATA_W    = 32;
  localparam int unsigned DEF_NUM_LINES = 24;
  localparam int unsigned DEF_VEC_W     = 5;
  localparam logic [31:0] DEF_BASE_ADDR = 32'hFEC0_0000;
  localparam logic [31:0] DEF_PIN_OFS   = 32'h0000_0020;
  // lines 0, 2, 8 and 13 are never raised by a message
  localparam logic [23:0] DEF_RSV_MASK  = 24'h00_2105;
endpackage

// File: rtl/msgirq_decode.sv
module msgirq_decode
  import msgirq_pkg::*;
#(
  parameter int unsigned ADDR_W    = DEF_ADDR_W,
  parameter int unsigned DATA_W    = DEF_DATA_W,
  parameter int unsigned NUM_LINES = DEF_NUM_LINES,
  parameter int unsigned VEC_W     = DEF_VEC_W,
  parameter logic [ADDR_W-1:0] BASE_ADDR = DEF_BASE_ADDR,
  parameter logic [ADDR_W-1:0] PIN_OFS   = DEF_PIN_OFS,
  parameter logic [NUM_LINES-1:0] RSV_MASK = DEF_RSV_MASK
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_valid,
  input  logic                 bus_write,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  input  logic                 ctrl_enable,
  input  logic                 cap_ok,
  input  logic [NUM_LINES-1:0] line_level,
  input  logic [NUM_LINES-1:0] line_en,
  output logic                 claim,
  output logic [NUM_LINES-1:0] set_vec,
  output logic                 mode_fault
);
  localparam logic [ADDR_W-1:0] TARGET = BASE_ADDR + PIN_OFS;

  logic [VEC_W-1:0]     vec;
  logic [NUM_LINES-1:0] sel;
  logic [NUM_LINES-1:0] legal_sel;
  logic                 wr_hit;

  assign vec = bus_wdata[VEC_W-1:0];

  // one-hot line select; numbers beyond the last line select nothing
  for (genvar g = 0; g < NUM_LINES; g++) begin : g_sel
    assign sel[g] = (vec == VEC_W'(g));
  end

  assign legal_sel  = sel & ~RSV_MASK;
  assign claim      = bus_valid && (bus_addr == TARGET) && ctrl_enable && cap_ok;
  assign wr_hit     = claim && bus_write;
  assign set_vec    = {NUM_LINES{wr_hit}} & legal_sel & ~line_level & line_en;
  assign mode_fault = wr_hit && |(legal_sel & line_level);

  assert_onehot_set_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(set_vec));
  assert_no_reserved_R6: assert property (@(posedge clk) disable iff (rst)
    (set_vec & RSV_MASK) == '0);
  assert_gate_R3: assert property (@(posedge clk) disable iff (rst)
    !(ctrl_enable && cap_ok) |-> (set_vec == '0 && !mode_fault));
endmodule

// File: rtl/msgirq_pending.sv
module msgirq_pending #(
  parameter int unsigned NUM_LINES = 24
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] set_vec,
  input  logic [NUM_LINES-1:0] clr_vec,
  input  logic                 fault,
  output logic [NUM_LINES-1:0] pend_q,
  output logic [NUM_LINES-1:0] pend_d,
  output logic                 err_q
);
  // a set in the same cycle as a clear keeps the bit
  assign pend_d = (pend_q & ~clr_vec) | set_vec;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      err_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      if (fault) err_q <= 1'b1;
    end
  end

  assert_set_wins_R10: assert property (@(posedge clk) disable iff (rst)
    (set_vec != '0) |=> ((pend_q & $past(set_vec)) == $past(set_vec)));
  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    err_q |=> err_q);
endmodule

// File: rtl/msgirq_arbiter.sv
module msgirq_arbiter #(
  parameter int unsigned NUM_LINES = 24,
  localparam int unsigned LINE_W = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] pend_d,
  input  logic                 dlv_ready,
  output logic                 dlv_valid,
  output logic [LINE_W-1:0]    dlv_line
);
  logic              dv_q;
  logic [LINE_W-1:0] dl_q;
  logic [LINE_W-1:0] last_q;
  logic [LINE_W-1:0] base;
  logic [LINE_W-1:0] pick;
  logic              found;
  logic              hold;

  assign hold = dv_q && !dlv_ready;

  always_comb begin
    base  = (dv_q && dlv_ready) ? dl_q : last_q;
    found = 1'b0;
    pick  = '0;
    for (int i = 0; i < NUM_LINES; i++) begin
      int idx;
      idx = int'(base) + 1 + i;
      if (idx >= int'(NUM_LINES)) idx = idx - int'(NUM_LINES);
      if (!found && pend_d[idx]) begin
        found = 1'b1;
        pick  = LINE_W'(idx);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dv_q   <= 1'b0;
      dl_q   <= '0;
      last_q <= LINE_W'(NUM_LINES - 1);
    end else if (!hold) begin
      dv_q   <= found;
      dl_q   <= pick;
      last_q <= base;
    end
  end

  assign dlv_valid = dv_q;
  assign dlv_line  = dl_q;

  assert_hold_R12: assert property (@(posedge clk) disable iff (rst)
    (dlv_valid && !dlv_ready) |=> (dlv_valid && $stable(dlv_line)));
endmodule

// File: rtl/msgirq_decoder.sv
module msgirq_decoder
  import msgirq_pkg::*;
#(
  parameter int unsigned ADDR_W    = DEF_ADDR_W,
  parameter int unsigned DATA_W    = DEF_DATA_W,
  parameter int unsigned NUM_LINES = DEF_NUM_LINES,
  parameter int unsigned VEC_W     = DEF_VEC_W,
  parameter logic [ADDR_W-1:0] BASE_ADDR = DEF_BASE_ADDR,
  parameter logic [ADDR_W-1:0] PIN_OFS   = DEF_PIN_OFS,
  parameter logic [NUM_LINES-1:0] RSV_MASK = DEF_RSV_MASK,
  localparam int unsigned LINE_W = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_valid,
  input  logic                 bus_write,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  output logic                 bus_claim,
  input  logic                 ctrl_enable,
  input  logic                 ext_enable,
  input  logic                 cap_request,
  output logic                 cap_status,
  input  logic [NUM_LINES-1:0] line_level,
  input  logic [NUM_LINES-1:0] line_en,
  output logic [NUM_LINES-1:0] pending,
  output logic                 mode_err,
  output logic                 dlv_valid,
  output logic [LINE_W-1:0]    dlv_line,
  input  logic                 dlv_ready
);
  logic                 cap_ok;
  logic                 claim_c;
  logic                 fault_c;
  logic [NUM_LINES-1:0] set_vec;
  logic [NUM_LINES-1:0] clr_vec;
  logic [NUM_LINES-1:0] pend_d;

  assign cap_ok = cap_request && ext_enable;

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_status <= 1'b0;
      bus_claim  <= 1'b0;
    end else begin
      cap_status <= cap_ok;
      bus_claim  <= claim_c;
    end
  end

  assign bus_rdata = '0;

  msgirq_decode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_LINES(NUM_LINES), .VEC_W(VEC_W),
    .BASE_ADDR(BASE_ADDR), .PIN_OFS(PIN_OFS), .RSV_MASK(RSV_MASK)
  ) u_decode (
    .clk(clk), .rst(rst),
    .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .ctrl_enable(ctrl_enable), .cap_ok(cap_ok),
    .line_level(line_level), .line_en(line_en),
    .claim(claim_c), .set_vec(set_vec), .mode_fault(fault_c)
  );

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_clr
    assign clr_vec[g] = dlv_valid && dlv_ready && (dlv_line == LINE_W'(g));
  end

  msgirq_pending #(.NUM_LINES(NUM_LINES)) u_pending (
    .clk(clk), .rst(rst),
    .set_vec(set_vec), .clr_vec(clr_vec), .fault(fault_c),
    .pend_q(pending), .pend_d(pend_d), .err_q(mode_err)
  );

  msgirq_arbiter #(.NUM_LINES(NUM_LINES)) u_arb (
    .clk(clk), .rst(rst),
    .pend_d(pend_d), .dlv_ready(dlv_ready),
    .dlv_valid(dlv_valid), .dlv_line(dlv_line)
  );

  assert_offer_pending_R9: assert property (@(posedge clk) disable iff (rst)
    dlv_valid |-> pending[dlv_line]);
  assert_clear_on_accept_R9: assert property (@(posedge clk) disable iff (rst)
    (dlv_valid && dlv_ready && !set_vec[dlv_line]) |=> !pending[$past(dlv_line)]);
  assert_cap_ext_R4: assert property (@(posedge clk) disable iff (rst)
    !$past(ext_enable) |-> !cap_status);
endmodule

// File: tb/test_msgirq_decoder.sv
`timescale 1ns/1ps
module test_msgirq_decoder;
  localparam logic [31:0] TGT = 32'hFEC0_0020;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [31:0] bus_addr = '0, bus_wdata = '0, bus_rdata;
  logic        bus_claim;
  logic        ctrl_enable = 1'b1, ext_enable = 1'b1, cap_request = 1'b1;
  logic        cap_status;
  logic [23:0] line_level = '0, line_en = '1, pending;
  logic        mode_err, dlv_valid, dlv_ready = 1'b0;
  logic [4:0]  dlv_line;
  int          n_chk = 0, n_bad = 0;
  bit          done = 0;

  always #2.5 clk = ~clk;

  msgirq_decoder i_msgirq_decoder (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_claim(bus_claim), .ctrl_enable(ctrl_enable), .ext_enable(ext_enable),
    .cap_request(cap_request), .cap_status(cap_status), .line_level(line_level),
    .line_en(line_en), .pending(pending), .mode_err(mode_err),
    .dlv_valid(dlv_valid), .dlv_line(dlv_line), .dlv_ready(dlv_ready)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; bus_valid = 1'b0; dlv_ready = 1'b0;
    ctrl_enable = 1'b1; ext_enable = 1'b1; cap_request = 1'b1;
    line_level = '0; line_en = '1;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic cyc(logic [31:0] a, logic [31:0] d, logic w);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = w; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 pending", 32'(pending), 0);
    check("R1 dlv_valid", 32'(dlv_valid), 0);
    check("R1 mode_err", 32'(mode_err), 0);
    check("R1 bus_claim", 32'(bus_claim), 0);
  endtask

  task automatic t_basic();
    do_reset();
    cyc(TGT, 32'hABCD_EF07, 1'b1);
    check("R2 set line 7 upper bits ignored", 32'(pending), 32'h80);
    check("R2 claim", 32'(bus_claim), 1);
    check("R9 valid same edge", 32'(dlv_valid), 1);
    check("R9 line", 32'(dlv_line), 7);
    cyc(TGT + 32'h4, 32'h5, 1'b1);
    check("R2 other address", 32'(pending), 32'h80);
    check("R2 no claim other address", 32'(bus_claim), 0);
    cyc(TGT, 32'h23, 1'b1);
    check("R2 data 0x23 is line 3", 32'(pending), 32'h88);
  endtask

  task automatic t_gate();
    do_reset();
    ctrl_enable = 1'b0;
    cyc(TGT, 5, 1'b1);
    check("R3 ctrl off", 32'(pending), 0);
    check("R3 ctrl off claim", 32'(bus_claim), 0);
    ctrl_enable = 1'b1; ext_enable = 1'b0;
    @(negedge clk);
    check("R4 cap low when ext off", 32'(cap_status), 0);
    cyc(TGT, 5, 1'b1);
    check("R3 ext off", 32'(pending), 0);
    ext_enable = 1'b1; cap_request = 1'b0;
    cyc(TGT, 5, 1'b1);
    check("R3 cap off", 32'(pending), 0);
    check("R4 cap low when request off", 32'(cap_status), 0);
    cap_request = 1'b1;
    @(negedge clk);
    check("R4 cap high", 32'(cap_status), 1);
    cyc(TGT, 5, 1'b1);
    check("R3 all on", 32'(pending), 32'h20);
  endtask

  task automatic t_range();
    do_reset();
    cyc(TGT, 24, 1'b1);
    check("R5 line 24", 32'(pending), 0);
    cyc(TGT, 31, 1'b1);
    check("R5 line 31", 32'(pending), 0);
    cyc(TGT, 32'h38, 1'b1);
    check("R5 data 0x38", 32'(pending), 0);
    cyc(TGT, 23, 1'b1);
    check("R5 line 23 ok", 32'(pending), 32'h80_0000);
  endtask

  task automatic t_reserved();
    do_reset();
    cyc(TGT, 0, 1'b1);
    cyc(TGT, 2, 1'b1);
    cyc(TGT, 8, 1'b1);
    cyc(TGT, 13, 1'b1);
    check("R6 reserved lines", 32'(pending), 0);
    check("R6 nothing offered", 32'(dlv_valid), 0);
    cyc(TGT, 1, 1'b1);
    check("R6 line 1 ok", 32'(pending), 32'h2);
  endtask

  task automatic t_level();
    do_reset();
    line_level = 24'h10;
    cyc(TGT, 4, 1'b1);
    check("R7 level dropped", 32'(pending), 0);
    check("R7 error set", 32'(mode_err), 1);
    cyc(TGT, 5, 1'b1);
    check("R7 edge line still works", 32'(pending), 32'h20);
    check("R7 error sticky", 32'(mode_err), 1);
    do_reset();
    check("R1 reset clears error", 32'(mode_err), 0);
  endtask

  task automatic t_disabled();
    do_reset();
    line_en = ~24'h40;
    cyc(TGT, 6, 1'b1);
    check("R8 disabled dropped", 32'(pending), 0);
    check("R8 no error", 32'(mode_err), 0);
  endtask

  task automatic t_order();
    do_reset();
    cyc(TGT, 10, 1'b1);
    cyc(TGT, 3, 1'b1);
    check("R12 hold line", 32'(dlv_line), 10);
    check("R12 hold valid", 32'(dlv_valid), 1);
    do_reset();
    cyc(TGT, 15, 1'b1);
    cyc(TGT, 4, 1'b1);
    cyc(TGT, 18, 1'b1);
    check("R11 first offered", 32'(dlv_line), 15);
    @(negedge clk); dlv_ready = 1'b1;
    @(negedge clk);
    check("R9 cleared 15", 32'(pending), 32'h4_0010);
    check("R11 next above", 32'(dlv_line), 18);
    @(negedge clk);
    check("R11 wrap", 32'(dlv_line), 4);
    @(negedge clk);
    dlv_ready = 1'b0;
    check("R9 drained", 32'(pending), 0);
    check("R9 valid low", 32'(dlv_valid), 0);
  endtask

  task automatic t_setwins();
    do_reset();
    cyc(TGT, 9, 1'b1);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = TGT; bus_wdata = 9; dlv_ready = 1'b1;
    @(negedge clk);
    bus_valid = 1'b0; dlv_ready = 1'b0;
    check("R10 bit kept", 32'(pending), 32'h200);
    check("R10 reoffered", 32'(dlv_line), 9);
    @(negedge clk); dlv_ready = 1'b1;
    @(negedge clk); dlv_ready = 1'b0;
    check("R10 later clear", 32'(pending), 0);
  endtask

  task automatic t_read();
    do_reset();
    cyc(TGT, 32'h7, 1'b0);
    check("R13 read claimed", 32'(bus_claim), 1);
    check("R13 read data", bus_rdata, 0);
    check("R13 read sets nothing", 32'(pending), 0);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_gate();
    t_range();
    t_reserved();
    t_level();
    t_disabled();
    t_order();
    t_setwins();
    t_read();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule